// File: doc/BRIEF.md
# I2C SCL Quarter-Period Timing Generator

This block paces the clock line of an I2C master. Software loads a 9-bit divide value `D` and an 8-bit SDA hold count through a three-register write/read port. While the block is enabled and the byte engine asserts `run_i`, each SCL period lasts `4*D` system clock cycles and is split into four quarters of `D` cycles. The block pulls SCL low for the first two quarters and releases it for the last two.

The byte engine gets a pulse in the last cycle of every quarter, a sample pulse at the middle of the high phase, and an SDA change pulse a programmed number of cycles after SCL falls. If a target holds SCL low while the block has released it, the quarter count freezes until the line reads high again. A new divide value written during a period takes effect at the start of the next period. Computing `D` from clock rates is left to software.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, register 0 reads 0x14, register 1 reads 0x00 and register 2 reads 0x07. SCL is released and no strobe is active.
- R2: In register 0 (reg_sel_i = 0), bit 0 is the module enable and bits [7:1] are the low 7 bits of the divide value. A written value reads back unchanged.
- R3: In register 1 (reg_sel_i = 1), bits [1:0] are the upper 2 bits of the divide value and bits [3:2] are an independent stored field. Bits [7:4] read 0. Register 2 holds the SDA hold count.
- R4: While running, SCL is pulled low (scl_oe_o = 1) for the first `2*D` cycles of each period and released for the next `2*D`. The first low cycle is the cycle in which running begins.
- R5: A programmed divide value below 10 acts as 10. The register still reads back the raw value.
- R6: qend_o pulses in the last cycle of each quarter. sample_o pulses in the last cycle of quarter 2, while SCL is released and reads high.
- R7: sda_chg_o pulses once per period, exactly `hold` cycles after the first cycle in which SCL is pulled low. A hold of 0 gives a pulse in that same cycle.
- R8: While SCL is released but reads low, the quarter count holds and no strobe fires. Every later event of that period is delayed by the number of held cycles.
- R9: A divide value written during a period leaves that period's timing unchanged and applies from the next period on.
- R10: When the enable bit is 0 or run_i is 0, SCL is released and no strobe fires. The next start begins at quarter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control low, 1 control high, 2 hold |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| run_i | input | 1 | Byte engine requests SCL clocking |
| scl_i | input | 1 | Synchronized SCL line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| qtr_o | output | 2 | Current quarter index |
| qend_o | output | 1 | Last cycle of a quarter |
| sample_o | output | 1 | Mid-high-phase sample strobe |
| sda_chg_o | output | 1 | SDA may change in this cycle |

## Verification
The hardest situation to reach is a target stretching the clock in the middle of the released phase, because it needs the line to read low after the block has already let go. The bench models SCL as a wired-AND of the block's pull and a target pull. It asserts the target pull a few cycles into quarter 2 and holds it for a fixed count. The bench then expects every later event of that period to shift by exactly that count. A divide rewrite in the middle of a period is timed the same way, a few cycles after the start.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  localparam int DIV_W    = 9;
  localparam int HOLD_W   = 8;
  localparam int REG_W    = 8;
  localparam int DIV_MIN  = 10;
  localparam int DIV_RST  = 10;
  localparam int HOLD_RST = 7;

  localparam logic [1:0] SEL_CTL_LO = 2'd0;
  localparam logic [1:0] SEL_CTL_HI = 2'd1;
  localparam logic [1:0] SEL_HOLD   = 2'd2;

  typedef logic [1:0] qtr_t;
endpackage

// File: rtl/sclgen_regs.sv
module sclgen_regs
  import i2c_sclgen_pkg::*;
#(
  parameter int DW    = DIV_W,
  parameter int HW    = HOLD_W,
  parameter int RW    = REG_W,
  parameter int DMIN  = DIV_MIN,
  parameter int DRST  = DIV_RST,
  parameter int HRST  = HOLD_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] rdata_o,
  output logic          en_o,
  output logic [DW-1:0] div_o,
  output logic [HW-1:0] hold_o
);
  localparam int LO_W  = RW - 1;
  localparam int HI_W  = DW - LO_W;
  localparam int AUX_W = 2;
  localparam logic [DW-1:0] MIN_V = DW'(DMIN);
  localparam logic [DW-1:0] RST_V = DW'(DRST);

  logic            en_q;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [AUX_W-1:0] aux_q;
  logic [HW-1:0]   hold_q;
  logic [DW-1:0]   raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lo_q   <= RST_V[LO_W-1:0];
      hi_q   <= RST_V[DW-1:LO_W];
      aux_q  <= '0;
      hold_q <= HW'(HRST);
    end else if (we_i) begin
      case (sel_i)
        SEL_CTL_LO: begin
          en_q <= wdata_i[0];
          lo_q <= wdata_i[RW-1:1];
        end
        SEL_CTL_HI: begin
          hi_q  <= wdata_i[HI_W-1:0];
          aux_q <= wdata_i[HI_W+AUX_W-1:HI_W];
        end
        SEL_HOLD: hold_q <= wdata_i[HW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CTL_LO: rdata_o = {lo_q, en_q};
      SEL_CTL_HI: rdata_o = RW'({aux_q, hi_q});
      SEL_HOLD:   rdata_o = RW'(hold_q);
      default:    rdata_o = '0;
    endcase
  end

  assign raw    = {hi_q, lo_q};
  assign div_o  = (raw < MIN_V) ? MIN_V : raw;  // clamp to legal floor
  assign en_o   = en_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/sclgen_quarter.sv
module sclgen_quarter
  import i2c_sclgen_pkg::*;
#(
  parameter int DW   = DIV_W,
  parameter int DMIN = DIV_MIN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [DW-1:0] div_i,
  input  logic          scl_i,
  output logic          scl_oe_o,
  output logic          qend_o,
  output logic          sample_o,
  output qtr_t          qtr_o
);
  logic [DW-1:0] cnt_q, div_act_q;
  qtr_t          qtr_q;
  logic          halt, last, tick;

  assign halt = qtr_q[1] & ~scl_i;            // released but held low by target
  assign last = (cnt_q == div_act_q - DW'(1));
  assign tick = active_i & ~halt & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      qtr_q     <= '0;
      div_act_q <= DW'(DMIN);
    end else if (!active_i) begin
      cnt_q     <= '0;
      qtr_q     <= '0;
      div_act_q <= div_i;
    end else if (!halt) begin
      if (last) begin
        cnt_q <= '0;
        qtr_q <= qtr_q + 2'd1;
        if (qtr_q == 2'd3) div_act_q <= div_i;  // period boundary
      end else begin
        cnt_q <= cnt_q + DW'(1);
      end
    end
  end

  assign scl_oe_o = active_i & ~qtr_q[1];
  assign qend_o   = tick;
  assign sample_o = tick & (qtr_q == 2'd2);
  assign qtr_o    = qtr_q;

  a_r8_freeze_on_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && halt) |=> (!active_i || ($stable(cnt_q) && $stable(qtr_q))));
  a_r9_div_only_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !(tick && qtr_q == 2'd3)) |=> $stable(div_act_q));
  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_act_q);
  a_r10_idle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0 && qtr_q == 2'd0));
endmodule

// File: rtl/sclgen_hold.sv
module sclgen_hold
  import i2c_sclgen_pkg::*;
#(
  parameter int HW = HOLD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          scl_oe_i,
  input  logic [HW-1:0] hold_i,
  output logic          sda_chg_o
);
  logic          oe_q, armed_q, fall;
  logic [HW-1:0] hcnt_q;

  assign fall = scl_oe_i & ~oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q    <= 1'b0;
      armed_q <= 1'b0;
      hcnt_q  <= '0;
    end else begin
      oe_q <= scl_oe_i;
      if (!active_i) begin
        armed_q <= 1'b0;
      end else if (fall) begin
        armed_q <= (hold_i != '0);
        hcnt_q  <= HW'(1);                     // counts cycles since fall
      end else if (armed_q) begin
        if (hcnt_q == hold_i) armed_q <= 1'b0;
        else                  hcnt_q  <= hcnt_q + HW'(1);
      end
    end
  end

  assign sda_chg_o = active_i &
                     ((fall & (hold_i == '0)) | (armed_q & (hcnt_q == hold_i)));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |=> !sda_chg_o);
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_sclgen_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int HW = HOLD_W,
  parameter int RW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic          run_i,
  input  logic          scl_i,
  output logic          scl_oe_o,
  output logic [1:0]    qtr_o,
  output logic          qend_o,
  output logic          sample_o,
  output logic          sda_chg_o
);
  logic          en, active;
  logic [DW-1:0] div;
  logic [HW-1:0] hold;

  sclgen_regs #(.DW(DW), .HW(HW), .RW(RW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .en_o(en), .div_o(div), .hold_o(hold)
  );

  assign active = en & run_i;

  sclgen_quarter #(.DW(DW)) u_qtr (
    .clk_i, .rst_ni, .active_i(active), .div_i(div), .scl_i,
    .scl_oe_o, .qend_o, .sample_o, .qtr_o
  );

  sclgen_hold #(.HW(HW)) u_hold (
    .clk_i, .rst_ni, .active_i(active), .scl_oe_i(scl_oe_o),
    .hold_i(hold), .sda_chg_o
  );

  a_r6_sample_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (!scl_oe_o && scl_i));
  a_r10_quiet_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!scl_oe_o && !qend_o && !sample_o && !sda_chg_o));
endmodule

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, run = 1'b0, tgt_low = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic scl_oe, qend, sample, sda_chg, scl_line;
  logic [1:0] qtr;

  always #4 clk = ~clk;   // 125 MHz

  assign scl_line = ~scl_oe & ~tgt_low;  // wired-AND of master and target

  i2c_scl_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .run_i(run), .scl_i(scl_line),
    .scl_oe_o(scl_oe), .qtr_o(qtr), .qend_o(qend), .sample_o(sample),
    .sda_chg_o(sda_chg)
  );

  int checks = 0, failures = 0, cyc = 0;
  string cur_tag = "R1";
  typedef struct { int c; int k; } ev_t;   // k: 0 fall,1 sda,2 qend,3 sample,4 release
  ev_t exp_q[$];
  logic oe_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input int c, input int k);
    ev_t e;
    int i;
    e.c = c; e.k = k;
    for (i = 0; i < exp_q.size(); i++)
      if (exp_q[i].c > c || (exp_q[i].c == c && exp_q[i].k > k)) break;
    exp_q.insert(i, e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit obs [5];
      obs[0] = scl_oe & ~oe_prev;
      obs[1] = sda_chg;
      obs[2] = qend;
      obs[3] = sample;
      obs[4] = ~scl_oe & oe_prev;
      for (int k = 0; k < 5; k++) begin
        if (obs[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, cur_tag, "unexpected event code", cyc * 8 + k, -1);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            chk(e.c == cyc && e.k == k, cur_tag, "event code(cycle*8+kind)",
                cyc * 8 + k, e.c * 8 + e.k);
          end
        end
      end
      oe_prev = scl_oe;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_to(input int c);
    while (cyc != c) step();
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    we = 1'b1; sel = s; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [7:0] e, input string tag);
    sel = s; #1;
    chk(rdata == e, tag, "register read", rdata, e);
  endtask

  task automatic cfg(input int d, input int h);
    wr(2'd0, {d[6:0], 1'b1});
    wr(2'd1, {4'd0, 2'b10, d[8:7]});
    wr(2'd2, h[7:0]);
  endtask

  task automatic gen_period(inout int t, input int d, input int h, input int s);
    push(t, 0);
    push(t + h, 1);
    push(t + d - 1, 2);
    push(t + 2*d - 1, 2);
    push(t + 2*d, 4);
    push(t + 3*d - 1 + s, 2);
    push(t + 3*d - 1 + s, 3);
    push(t + 4*d - 1 + s, 2);
    t = t + 4*d + s;
  endtask

  // stretch of st_len cycles placed 2 cycles into quarter 2 of the first period
  task automatic run_seq(input int d, input int h, input int n, input int st_len,
                         input string tag);
    int k, t;
    cur_tag = tag;
    k = cyc; t = k;
    for (int p = 0; p < n; p++) gen_period(t, d, h, (p == 0) ? st_len : 0);
    run = 1'b1;
    if (st_len > 0) begin
      wait_to(k + 2*d + 2);
      tgt_low = 1'b1;
      wait_to(k + 2*d + 2 + st_len);
      tgt_low = 1'b0;
    end
    wait_to(t);
    run = 1'b0;
    step(); step();
    chk(exp_q.size() == 0, tag, "missing events", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k, t, busy;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd_chk(2'd0, 8'h14, "R1");
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h07, "R1");
    chk(scl_oe == 1'b0 && qend == 1'b0 && sda_chg == 1'b0, "R1", "idle outputs",
        {scl_oe, qend, sda_chg}, 0);
    // R2 control low layout
    wr(2'd0, 8'hA5);
    rd_chk(2'd0, 8'hA5, "R2");
    // R3 control high layout and hold register
    wr(2'd1, 8'hFF);
    rd_chk(2'd1, 8'h0F, "R3");
    wr(2'd1, 8'h0C);
    rd_chk(2'd1, 8'h0C, "R3");
    wr(2'd2, 8'h11);
    rd_chk(2'd2, 8'h11, "R3");
    // R10 disabled with run high, then enabled with run low
    cur_tag = "R10";
    wr(2'd0, 8'h14);
    run = 1'b1; busy = 0;
    repeat (40) begin step(); if (scl_oe | qend | sample | sda_chg) busy++; end
    run = 1'b0;
    chk(busy == 0, "R10", "activity while disabled", busy, 0);
    wr(2'd0, 8'h15);
    busy = 0;
    repeat (40) begin step(); if (scl_oe | qend | sample | sda_chg) busy++; end
    chk(busy == 0, "R10", "activity with run low", busy, 0);
    // R4 R6 R7 basic periods
    cfg(10, 3);
    run_seq(10, 3, 2, 0, "R4");
    cfg(300, 17);
    run_seq(300, 17, 1, 0, "R6");
    cfg(23, 0);
    run_seq(23, 0, 2, 0, "R7");
    // R5 divide below floor acts as 10
    cfg(3, 5);
    rd_chk(2'd0, 8'h07, "R5");
    run_seq(10, 5, 2, 0, "R5");
    // R8 clock stretch in high phase
    cfg(16, 5);
    run_seq(16, 5, 2, 9, "R8");
    // R9 divide change mid-period
    cfg(12, 4);
    cur_tag = "R9";
    k = cyc; t = k;
    gen_period(t, 12, 4, 0);
    gen_period(t, 20, 4, 0);
    gen_period(t, 20, 4, 0);
    run = 1'b1;
    wait_to(k + 5);
    wr(2'd0, {7'd20, 1'b1});
    wait_to(t);
    run = 1'b0;
    step(); step();
    chk(exp_q.size() == 0, "R9", "missing events", exp_q.size(), 0);
    // R4 largest divide
    cfg(511, 7);
    run_seq(511, 7, 1, 0, "R4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule